// File: doc/BRIEF.md
# Indexed Extended Register Window

This block is the register-file front end that sits behind a serial-bus protocol engine. The engine presents a plain parallel register bus: an address, write data, a write strobe and combinational read data. A small bank of ordinary registers is reached directly at addresses 00h upward. Two extra registers, a clock-control byte and a PWM-control byte, have no address of their own. They share one window address.

A 3-bit index, written to a separate selector address, decides which hidden slot the window reaches. The index stays in force until the selector is written again. Each hidden register keeps its own storage, so changing the index never changes what any register holds. All register contents drive parallel outputs for neighbouring logic.

Top module: `regwin_top`

## Requirements
- R1: While the active-low power-on reset `rst_n` is low, every register is cleared: `clk_ctrl_o`, `pwm_ctrl_o`, `direct_o` and the index all become 0.
- R2: A write to the selector address 1Ch stores `bus_wdata[2:0]` as the index. A read of 1Ch returns the index in bits 2:0, with bits 7:3 zero.
- R3: With index 5, a write to the window address 1Ah updates `clk_ctrl_o` at the next clock edge, and a read of 1Ah returns that register.
- R4: With index 6, a write to 1Ah updates `pwm_ctrl_o` at the next clock edge, and a read of 1Ah returns that register.
- R5: The index stays in effect across any number of window accesses, so repeated window writes keep hitting the same hidden register.
- R6: With an index other than 5 or 6, a window write changes no register, and a window read returns 00h.
- R7: Changing the index leaves the contents of both hidden registers unchanged.
- R8: Direct register k (k from 0 to DIRECT_COUNT-1) is written and read at address k. Its byte appears on `direct_o[8k+7:8k]`.
- R9: Any address that is not a direct register, 1Ah or 1Ch reads 00h, and a write to it has no effect.
- R10: When `bus_we` is low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| clk_ctrl_o | output | 8 | Hidden clock-control register (index 5) |
| pwm_ctrl_o | output | 8 | Hidden PWM-control register (index 6) |
| direct_o | output | 8*DIRECT_COUNT | Direct registers, register k in bits 8k+7:8k |

## Verification
The hardest case to reach is the retention case. Both hidden registers must hold distinct non-zero values, and then the index must be moved away and back, or parked on an unmapped slot, while window writes continue. Only then does a fault that leaks a write into the wrong slot, or clears storage on an index change, become visible. The stimulus table first loads different patterns through indices 5 and 6, then switches the index back and forth and to empty slots. After each step it checks both hidden outputs and the window read-back.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 3;
    localparam int SLOTS  = 1 << IDX_W;

    localparam logic [ADDR_W-1:0] SEL_ADDR = 8'h1C;
    localparam logic [ADDR_W-1:0] WIN_ADDR = 8'h1A;

    localparam int CLK_SLOT = 5;
    localparam int PWM_SLOT = 6;

    localparam logic [SLOTS-1:0] SLOT_PRESENT =
        SLOTS'(1 << CLK_SLOT) | SLOTS'(1 << PWM_SLOT);
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int DIRECT_COUNT = 4
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [IDX_W-1:0]        index,
    output logic                    sel_hit,
    output logic                    win_hit,
    output logic [DIRECT_COUNT-1:0] direct_hit,
    output logic [SLOTS-1:0]        slot_hit
);
    assign sel_hit = (addr == SEL_ADDR);
    assign win_hit = (addr == WIN_ADDR);

    for (genvar k = 0; k < DIRECT_COUNT; k++) begin : g_direct
        assign direct_hit[k] = (addr == ADDR_W'(k));
    end

    // Only implemented slots can be selected; empty slots yield no hit.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_hit[s] = SLOT_PRESENT[s] && (index == IDX_W'(s));
    end
endmodule

// File: rtl/regwin_rdmux.sv
module regwin_rdmux
    import regwin_pkg::*;
#(
    parameter int DIRECT_COUNT = 4
) (
    input  logic                                 sel_hit,
    input  logic                                 win_hit,
    input  logic [DIRECT_COUNT-1:0]              direct_hit,
    input  logic [SLOTS-1:0]                     slot_hit,
    input  logic [IDX_W-1:0]                     index,
    input  logic [SLOTS-1:0][DATA_W-1:0]         hidden,
    input  logic [DIRECT_COUNT-1:0][DATA_W-1:0]  direct,
    output logic [DATA_W-1:0]                    rdata
);
    always_comb begin
        rdata = '0;
        if (sel_hit) begin
            rdata = DATA_W'(index);
        end
        if (win_hit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (slot_hit[s]) begin
                    rdata = rdata | hidden[s];
                end
            end
        end
        for (int k = 0; k < DIRECT_COUNT; k++) begin
            if (direct_hit[k]) begin
                rdata = rdata | direct[k];
            end
        end
    end
endmodule

// File: rtl/regwin_top.sv
module regwin_top
    import regwin_pkg::*;
#(
    parameter int DIRECT_COUNT = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  logic                             bus_we,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [DATA_W-1:0]                clk_ctrl_o,
    output logic [DATA_W-1:0]                pwm_ctrl_o,
    output logic [DIRECT_COUNT*DATA_W-1:0]   direct_o
);
    typedef struct packed {
        logic [IDX_W-1:0]                    index;
        logic [SLOTS-1:0][DATA_W-1:0]        hidden;
        logic [DIRECT_COUNT-1:0][DATA_W-1:0] direct;
    } state_t;

    state_t st_d, st_q;

    logic                    sel_hit;
    logic                    win_hit;
    logic [DIRECT_COUNT-1:0] direct_hit;
    logic [SLOTS-1:0]        slot_hit;
    logic [IDX_W-1:0]        idx_q;

    assign idx_q = st_q.index;

    regwin_decode #(.DIRECT_COUNT(DIRECT_COUNT)) u_decode (
        .addr       (bus_addr),
        .index      (st_q.index),
        .sel_hit    (sel_hit),
        .win_hit    (win_hit),
        .direct_hit (direct_hit),
        .slot_hit   (slot_hit)
    );

    regwin_rdmux #(.DIRECT_COUNT(DIRECT_COUNT)) u_rdmux (
        .sel_hit    (sel_hit),
        .win_hit    (win_hit),
        .direct_hit (direct_hit),
        .slot_hit   (slot_hit),
        .index      (st_q.index),
        .hidden     (st_q.hidden),
        .direct     (st_q.direct),
        .rdata      (bus_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            if (sel_hit) begin
                st_d.index = bus_wdata[IDX_W-1:0];
            end
            if (win_hit) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (slot_hit[s]) begin
                        st_d.hidden[s] = bus_wdata;
                    end
                end
            end
            for (int k = 0; k < DIRECT_COUNT; k++) begin
                if (direct_hit[k]) begin
                    st_d.direct[k] = bus_wdata;
                end
            end
        end
        // Slots with no register behind them hold no storage.
        for (int s = 0; s < SLOTS; s++) begin
            if (!SLOT_PRESENT[s]) begin
                st_d.hidden[s] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_ctrl_o = st_q.hidden[CLK_SLOT];
    assign pwm_ctrl_o = st_q.hidden[PWM_SLOT];
    assign direct_o   = st_q.direct;
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker
    import regwin_pkg::*;
#(
    parameter int DIRECT_COUNT = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [DATA_W-1:0]              bus_wdata,
    input logic                           bus_we,
    input logic [DATA_W-1:0]              bus_rdata,
    input logic [DATA_W-1:0]              clk_ctrl_o,
    input logic [DATA_W-1:0]              pwm_ctrl_o,
    input logic [DIRECT_COUNT*DATA_W-1:0] direct_o,
    input logic [IDX_W-1:0]               idx_q
);
    logic win_wr;
    logic unused_addr;
    assign win_wr      = bus_we && (bus_addr == WIN_ADDR);
    assign unused_addr = (bus_addr >= ADDR_W'(DIRECT_COUNT)) &&
                         (bus_addr != WIN_ADDR) && (bus_addr != SEL_ADDR);

    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (clk_ctrl_o == '0 && pwm_ctrl_o == '0 &&
                          direct_o == '0 && idx_q == '0));

    p_sel_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_ADDR) |-> (bus_rdata == DATA_W'(idx_q)));

    p_clk_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && idx_q == IDX_W'(CLK_SLOT)) |=> (clk_ctrl_o == $past(bus_wdata)));

    p_pwm_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && idx_q == IDX_W'(PWM_SLOT)) |=> (pwm_ctrl_o == $past(bus_wdata)));

    p_unmapped_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == WIN_ADDR) && idx_q != IDX_W'(CLK_SLOT) &&
         idx_q != IDX_W'(PWM_SLOT)) |-> (bus_rdata == '0));

    p_hidden_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> ($stable(clk_ctrl_o) && $stable(pwm_ctrl_o)));

    p_unused_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unused_addr |-> (bus_rdata == '0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(direct_o) && $stable(idx_q)));
endmodule

bind regwin_top regwin_checker #(.DIRECT_COUNT(DIRECT_COUNT)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .clk_ctrl_o (clk_ctrl_o),
    .pwm_ctrl_o (pwm_ctrl_o),
    .direct_o   (direct_o),
    .idx_q      (idx_q)
);

// File: tb/regwin_top_bench.sv
module regwin_top_bench;
    localparam int DC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_rdata;
    logic [7:0]    clk_ctrl_o;
    logic [7:0]    pwm_ctrl_o;
    logic [DC*8-1:0] direct_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    regwin_top #(.DIRECT_COUNT(DC)) u_regwin_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .clk_ctrl_o (clk_ctrl_o),
        .pwm_ctrl_o (pwm_ctrl_o),
        .direct_o   (direct_o)
    );

    // kind: 0 write, 1 read check, 2 clk_ctrl_o check, 3 pwm_ctrl_o check,
    // 4 direct_o byte check (addr gives the register number)
    typedef struct packed {
        logic [2:0] kind;
        logic [7:0] addr;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'h1C, 8'h05, 4'd2},  // R2 select clock slot
        '{3'd1, 8'h1C, 8'h05, 4'd2},  // R2 selector read-back
        '{3'd0, 8'h1A, 8'hA5, 4'd3},  // R3 window write
        '{3'd2, 8'h00, 8'hA5, 4'd3},  // R3
        '{3'd1, 8'h1A, 8'hA5, 4'd3},  // R3 window read
        '{3'd0, 8'h1A, 8'h3C, 4'd5},  // R5 second write same index
        '{3'd2, 8'h00, 8'h3C, 4'd5},  // R5
        '{3'd3, 8'h00, 8'h00, 4'd5},  // R5 other slot untouched
        '{3'd0, 8'h1C, 8'h06, 4'd4},  // R4 select pwm slot
        '{3'd0, 8'h1A, 8'h81, 4'd4},
        '{3'd3, 8'h00, 8'h81, 4'd4},  // R4
        '{3'd1, 8'h1A, 8'h81, 4'd4},  // R4
        '{3'd2, 8'h00, 8'h3C, 4'd7},  // R7 clock kept
        '{3'd0, 8'h1C, 8'h05, 4'd7},
        '{3'd1, 8'h1A, 8'h3C, 4'd7},  // R7 read back after switch
        '{3'd3, 8'h00, 8'h81, 4'd7},  // R7
        '{3'd0, 8'h1C, 8'h03, 4'd6},  // R6 empty slot
        '{3'd0, 8'h1A, 8'hFF, 4'd6},
        '{3'd1, 8'h1A, 8'h00, 4'd6},  // R6
        '{3'd2, 8'h00, 8'h3C, 4'd6},  // R6
        '{3'd3, 8'h00, 8'h81, 4'd6},  // R6
        '{3'd0, 8'h1C, 8'hFF, 4'd2},  // R2 upper bits dropped
        '{3'd1, 8'h1C, 8'h07, 4'd2},  // R2
        '{3'd0, 8'h1A, 8'h77, 4'd6},  // R6 slot 7 also empty
        '{3'd1, 8'h1A, 8'h00, 4'd6},  // R6
        '{3'd0, 8'h00, 8'h11, 4'd8},  // R8
        '{3'd0, 8'h03, 8'h44, 4'd8},
        '{3'd1, 8'h00, 8'h11, 4'd8},  // R8
        '{3'd1, 8'h03, 8'h44, 4'd8},  // R8
        '{3'd4, 8'h03, 8'h44, 4'd8},  // R8 output byte 3
        '{3'd0, 8'h10, 8'hEE, 4'd9},  // R9 unused address
        '{3'd1, 8'h10, 8'h00, 4'd9},  // R9
        '{3'd1, 8'h00, 8'h11, 4'd9},  // R9 neighbour unchanged
        '{3'd4, 8'h01, 8'h00, 4'd9}   // R9
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", clk_ctrl_o, 8'h00);
        check("R1", pwm_ctrl_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1", 8'h1C, 8'h00);
        check("R1", direct_o[7:0], 8'h00);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            case (VECS[i].kind)
                3'd0: wr(VECS[i].addr, VECS[i].data);
                3'd1: rd(tag, VECS[i].addr, VECS[i].data);
                3'd2: begin #1; check(tag, clk_ctrl_o, VECS[i].data); end
                3'd3: begin #1; check(tag, pwm_ctrl_o, VECS[i].data); end
                default: begin
                    #1;
                    check(tag, direct_o[VECS[i].addr[1:0]*8 +: 8], VECS[i].data);
                end
            endcase
        end

        // R10: strobe low, every writable address presented
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 8'h5A;
        bus_addr = 8'h1A; @(negedge clk);
        bus_addr = 8'h1C; @(negedge clk);
        bus_addr = 8'h00; @(negedge clk);
        rd("R10", 8'h1C, 8'h07);
        rd("R10", 8'h00, 8'h11);
        check("R10", clk_ctrl_o, 8'h3C);
        check("R10", pwm_ctrl_o, 8'h81);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        #1;
        check("R1", clk_ctrl_o, 8'h00);
        check("R1", pwm_ctrl_o, 8'h00);
        check("R1", direct_o[31:24], 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1", 8'h1C, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule